// File: doc/BRIEF.md
# Average Detector Bandwidth Stepper

This block is the digital half of a tracking average detector. An external comparator reports whether the analog input sits above the level that the block's counter represents. The counter then moves one code toward the input on every update, so that over time the count follows the average of the input. It does not regulate toward a fixed target.

Updates are paced in two stages. A divider turns the crystal clock into a base tick that fires once every 2·X clock cycles, where X is programmable from 1 to 2048. A second stage passes only one base tick in every 2^(10−s), where s is the bandwidth step index from 0 to 10. Two control pins move s. Each toggle of the raise pin doubles the tracking rate, and each toggle of the lower pin halves it. Both pins are asynchronous. Either edge of a pin counts as one toggle.

Top module: `avgdet_bw_stepper`

## Requirements
- R1: During and directly after reset, `bw_step` is 0 and `level` is midscale, 2^(CW−1).
- R2: The base tick fires once every 2·(`div_m1`+1) clock cycles. At step 10, every base tick is an update, so `level` changes once per 2·(`div_m1`+1) cycles while it is not at a limit.
- R3: A rising or falling edge on `bw_up_pin` is synchronized through two flops. It then raises `bw_step` by one. The new value shows on the third rising clock edge after the pin changes.
- R4: A rising or falling edge on `bw_dn_pin` is synchronized in the same way and lowers `bw_step` by one, with the same latency.
- R5: `bw_step` stays within 0 to 10. A raise toggle at step 10 is ignored, and a lower toggle at step 0 is ignored.
- R6: When synchronized raise and lower toggles land in the same cycle, `bw_step` is unchanged.
- R7: At step s, `level` updates once every 2^(10−s) base ticks.
- R8: On an update, `level` rises by one when `above_flag` is 1 and falls by one when it is 0.
- R9: `level` saturates: it stays at 2^CW−1 on a rise and at 0 on a fall.
- R10: Between updates, `level` does not change, whatever `above_flag` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_m1 | input | XW | Divider setting X−1 (base tick every 2·X cycles) |
| bw_up_pin | input | 1 | Asynchronous raise pin; each edge is one toggle |
| bw_dn_pin | input | 1 | Asynchronous lower pin; each edge is one toggle |
| above_flag | input | 1 | Comparator result: 1 when the input is above the level |
| level | output | CW | Tracking count |
| bw_step | output | 4 | Current bandwidth step index, 0 to 10 |

## Verification
The bench builds the block with CW = 4, so the count runs from 0 to 15 with midscale at 8. This lets a few dozen updates drive the count into both saturation limits. It keeps XW at 11 but drives only small divider values (X from 1 to 4). That keeps updates frequent enough to exercise the step-10 and step-9 rates cycle by cycle. Longer random runs at low steps check the pacing against the bench's own model of the two-stage divider.

// File: rtl/avgdet_pkg.sv
package avgdet_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_RAISE = 2'd1,
      STEP_LOWER = 2'd2
   } step_move_e;

   // Number of base ticks minus one between updates at a given step.
   function automatic logic [15:0] rate_limit(input int unsigned top, input int unsigned s);
      int unsigned sh;
      sh = (s > top) ? 0 : (top - s);
      return 16'((32'd1 << sh) - 32'd1);
   endfunction

endpackage

// File: rtl/avgdet_edge_sync.sv
module avgdet_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic toggled
);
   if (STAGES < 2) begin : g_bad_stages
      $error("avgdet_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= pin;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign toggled = chain[STAGES-1] ^ last_q;

endmodule

// File: rtl/avgdet_tick_div.sv
module avgdet_tick_div #(
   parameter int XW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] div_m1,
   output logic          tick
);
   if (XW < 1 || XW > 20) begin : g_bad_xw
      $error("avgdet_tick_div: XW out of range");
   end

   localparam int DW = XW + 1;

   logic [DW-1:0] dcnt;
   logic [DW-1:0] span_m1;

   // 2*(div_m1+1)-1
   assign span_m1 = {div_m1, 1'b1};
   assign tick    = (dcnt >= span_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)    dcnt <= '0;
      else if (tick) dcnt <= '0;
      else           dcnt <= dcnt + 1'b1;
   end

   AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (dcnt == '0)); // R2

endmodule

// File: rtl/avgdet_step_ctrl.sv
module avgdet_step_ctrl
   import avgdet_pkg::*;
#(
   parameter int NSTEP = 11,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up_ev,
   input  logic          dn_ev,
   output logic [SW-1:0] step
);
   localparam int TOP = NSTEP - 1;

   if (NSTEP < 2 || (1 << SW) < NSTEP) begin : g_bad_step
      $error("avgdet_step_ctrl: SW too narrow for NSTEP");
   end

   step_move_e    move;
   logic [SW-1:0] step_q;

   always_comb begin
      move = STEP_HOLD;
      if (up_ev && !dn_ev && step_q != SW'(TOP)) move = STEP_RAISE;
      if (dn_ev && !up_ev && step_q != '0)       move = STEP_LOWER;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= '0;
      else begin
         case (move)
            STEP_RAISE: step_q <= step_q + 1'b1;
            STEP_LOWER: step_q <= step_q - 1'b1;
            default:    step_q <= step_q;
         endcase
      end
   end

   assign step = step_q;

   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= SW'(TOP)); // R5
   AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ev && dn_ev) |=> $stable(step_q)); // R6
   AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ev && !dn_ev && step_q < SW'(TOP)) |=> (step_q == $past(step_q) + 1'b1)); // R3
   AST_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_ev && !up_ev && step_q != '0) |=> (step_q == $past(step_q) - 1'b1)); // R4
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_ev && !dn_ev) |=> $stable(step_q)); // R5

endmodule

// File: rtl/avgdet_rate_gate.sv
module avgdet_rate_gate
   import avgdet_pkg::*;
#(
   parameter int NSTEP = 11,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [SW-1:0] step,
   output logic          update
);
   localparam int TOP = NSTEP - 1;
   localparam int RW  = (TOP < 1) ? 1 : TOP;

   if (NSTEP > 17) begin : g_bad_nstep
      $error("avgdet_rate_gate: NSTEP too large for rate limit");
   end

   logic [RW-1:0] rcnt;
   logic [RW-1:0] lim;

   assign lim    = RW'(rate_limit(TOP, int'(step)));
   assign update = tick && (rcnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)      rcnt <= '0;
      else if (update) rcnt <= '0;
      else if (tick)   rcnt <= rcnt + 1'b1;
   end

   AST_GATE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      update |-> tick); // R7
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(rcnt)); // R7

endmodule

// File: rtl/avgdet_track_cnt.sv
module avgdet_track_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          update,
   input  logic          above,
   output logic [CW-1:0] level
);
   if (CW < 2) begin : g_bad_cw
      $error("avgdet_track_cnt: CW must be at least 2");
   end

   localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);
   localparam logic [CW-1:0] MAX = '1;

   logic [CW-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= MID;
      else if (update) begin
         if (above && lvl_q != MAX)      lvl_q <= lvl_q + 1'b1;
         else if (!above && lvl_q != '0) lvl_q <= lvl_q - 1'b1;
      end
   end

   assign level = lvl_q;

   AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(lvl_q)); // R10
   AST_LVL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (update && above && lvl_q != MAX) |=> (lvl_q == $past(lvl_q) + 1'b1)); // R8
   AST_LVL_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (update && !above && lvl_q != '0) |=> (lvl_q == $past(lvl_q) - 1'b1)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (update && above && lvl_q == MAX) |=> (lvl_q == MAX)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (update && !above && lvl_q == '0) |=> (lvl_q == '0)); // R9

endmodule

// File: rtl/avgdet_bw_stepper.sv
module avgdet_bw_stepper
   import avgdet_pkg::*;
#(
   parameter int CW     = 8,
   parameter int XW     = 11,
   parameter int NSTEP  = 11,
   parameter int SYNC_N = 2,
   localparam int SW    = $clog2(NSTEP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] div_m1,
   input  logic          bw_up_pin,
   input  logic          bw_dn_pin,
   input  logic          above_flag,
   output logic [CW-1:0] level,
   output logic [SW-1:0] bw_step
);
   logic [1:0] pins;
   logic [1:0] evs;
   logic       base_tick;
   logic       upd;

   assign pins = {bw_dn_pin, bw_up_pin};

   for (genvar p = 0; p < 2; p++) begin : g_pin
      avgdet_edge_sync #(.STAGES(SYNC_N)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (pins[p]),
         .toggled (evs[p])
      );
   end

   avgdet_step_ctrl #(.NSTEP(NSTEP), .SW(SW)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .up_ev (evs[0]),
      .dn_ev (evs[1]),
      .step  (bw_step)
   );

   avgdet_tick_div #(.XW(XW)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_m1 (div_m1),
      .tick   (base_tick)
   );

   avgdet_rate_gate #(.NSTEP(NSTEP), .SW(SW)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (base_tick),
      .step   (bw_step),
      .update (upd)
   );

   avgdet_track_cnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .update (upd),
      .above  (above_flag),
      .level  (level)
   );

   AST_TOP_UPD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (base_tick && bw_step == SW'(NSTEP - 1)) |-> upd); // R2

endmodule

// File: tb/sim_avgdet_bw_stepper.sv
`timescale 1ns/1ps
module sim_avgdet_bw_stepper;
   localparam int CW = 4;
   localparam int XW = 11;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [XW-1:0] div_m1 = '0;
   logic          up_pin = 1'b0;
   logic          dn_pin = 1'b0;
   logic          flag = 1'b0;
   logic [CW-1:0] level;
   logic [SW-1:0] step;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   avgdet_bw_stepper #(.CW(CW), .XW(XW)) u0 (
      .clk(clk), .rst_n(rst_n), .div_m1(div_m1),
      .bw_up_pin(up_pin), .bw_dn_pin(dn_pin), .above_flag(flag),
      .level(level), .bw_step(step)
   );

   // Reference model built from the requirements
   int m_u1, m_u2, m_u3, m_d1, m_d2, m_d3;
   int m_step, m_dc, m_rc, m_lvl;

   function automatic int lim_of(int s);
      return (1 << (10 - s)) - 1;
   endfunction

   always @(posedge clk) begin
      int ue, de, tk, up;
      if (!rst_n) begin
         m_u1 = 0; m_u2 = 0; m_u3 = 0; m_d1 = 0; m_d2 = 0; m_d3 = 0;
         m_step = 0; m_dc = 0; m_rc = 0; m_lvl = 1 << (CW - 1);
      end else begin
         ue = m_u2 ^ m_u3;
         de = m_d2 ^ m_d3;
         tk = (m_dc >= 2 * (int'(div_m1) + 1) - 1);
         up = tk && (m_rc >= lim_of(m_step));
         if (up) begin
            if (flag && m_lvl < (1 << CW) - 1) m_lvl++;
            else if (!flag && m_lvl > 0)       m_lvl--;
         end
         if (up) m_rc = 0; else if (tk) m_rc++;
         m_dc = tk ? 0 : m_dc + 1;
         if (ue && !de && m_step < 10) m_step++;
         else if (de && !ue && m_step > 0) m_step--;
         m_u3 = m_u2; m_u2 = m_u1; m_u1 = int'(up_pin);
         m_d3 = m_d2; m_d2 = m_d1; m_d1 = int'(dn_pin);
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cmp_model(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check("R8 level vs model", int'(level), m_lvl);
         check("R3 step vs model", int'(step), m_step);
      end
   endtask

   task automatic toggle_up(); up_pin = ~up_pin; cmp_model(4); endtask
   task automatic toggle_dn(); dn_pin = ~dn_pin; cmp_model(4); endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      process::self().srandom(32'd1234);
      tick_n(3);
      check("R1 step in reset", int'(step), 0);
      check("R1 level in reset", int'(level), 8);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 step after reset", int'(step), 0);
      check("R1 level after reset", int'(level), 8);

      // R3 latency: new step on third edge after pin change
      up_pin = 1'b1;
      tick_n(2);
      check("R3 no change before sync", int'(step), 0);
      tick_n(1);
      check("R3 rising edge raises", int'(step), 1);
      up_pin = 1'b0;
      tick_n(3);
      check("R3 falling edge raises", int'(step), 2);

      // R5 saturation at top
      for (int i = 0; i < 12; i++) toggle_up();
      check("R5 top saturation", int'(step), 10);

      // R2 step 10, X=3: one change per 6 cycles
      flag = 1'b0;
      div_m1 = 11'd2;
      while (level != 0) tick_n(1);
      flag = 1'b1;
      tick_n(7);
      v = int'(level);
      tick_n(6);
      check("R2 one update per 2X cycles", int'(level), v + 1);
      tick_n(6);
      check("R2 next update", int'(level), v + 2);

      // R9 saturation both ends, X=1
      div_m1 = '0;
      tick_n(40);
      check("R9 top saturation", int'(level), 15);
      flag = 1'b0;
      tick_n(40);
      check("R9 bottom saturation", int'(level), 0);
      flag = 1'b1;

      // R6 simultaneous toggles cancel
      tick_n(4);
      up_pin = ~up_pin; dn_pin = ~dn_pin;
      tick_n(5);
      check("R6 cancel", int'(step), 10);

      // R4 lower and R7 rate at step 9, X=1: one update per 4 cycles
      dn_pin = ~dn_pin;
      tick_n(4);
      check("R4 lower", int'(step), 9);
      flag = 1'b0;
      tick_n(12);
      flag = 1'b1;
      tick_n(5);
      v = int'(level);
      tick_n(4);
      check("R7 step 9 rate", int'(level), v + 1);

      // R5 bottom saturation
      for (int i = 0; i < 12; i++) toggle_dn();
      check("R5 bottom saturation", int'(step), 0);

      // R10: flag flips without update at step 0 (2048 cycles per update, X=1)
      v = int'(level);
      for (int i = 0; i < 20; i++) begin
         flag = ~flag;
         tick_n(1);
      end
      check("R10 no update no change", int'(level), m_lvl);

      // Constrained random against model
      for (int k = 0; k < 60; k++) begin
         div_m1 = XW'($urandom_range(0, 3));
         flag = 1'($urandom_range(0, 1));
         case ($urandom_range(0, 3))
            0: up_pin = ~up_pin;
            1: dn_pin = ~dn_pin;
            2: begin up_pin = ~up_pin; dn_pin = ~dn_pin; end
            default: ;
         endcase
         cmp_model($urandom_range(4, 200));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule